// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block shapes the SCL clock for an I2C master. It keeps its own high and low count pair for each of three speed modes. While `run` is asserted it drives SCL low for the low phase and then releases the line. It starts the high-phase timer only after a filtered copy of the line has been seen high, so a slow or stretched rising edge lengthens the period. The effective phase lengths add fixed overheads and the programmed edge and filter lengths to the counts. Software can therefore program counts that were computed for the bus rise and fall times.

A byte engine uses two one-cycle strobes. `sample_stb` marks the point where SCL is first seen high, which is the moment to sample SDA. `update_stb` marks the point, a programmed hold delay after SCL is pulled low, from which SDA may change. The sampled SCL passes through a synchroniser and a spike filter whose length is programmable. When `run` is low at the end of a high phase, the generator returns to idle with SCL released.

Top module: `scl_timing_gen`

## Requirements
- R1: After a synchronous reset, `scl_oe`, `sample_stb`, `update_stb` and `busy` are 0 and `scl_filt` is 1.
- R2: `speed_sel` 0 selects the standard pair (`std_hi`/`std_lo`), 1 selects the fast pair, 2 selects the high-speed pair, and 3 selects the standard pair.
- R3: Each low phase holds `scl_oe` at 1 for exactly lo + 1 + `rise_cyc` consecutive cycles, where lo is the selected low count.
- R4: After the low phase, `scl_oe` stays 0 while `scl_filt` is 0. The high count of hi + `spike_len` + 7 + `fall_cyc` cycles starts in the first cycle in which `scl_filt` is 1, and the next low phase starts when that count ends.
- R5: `scl_filt` follows `scl_in` through a 2-flop synchroniser. A change of the synchronised value is adopted only after it has lasted `spike_len`+1 consecutive cycles, so pulses of `spike_len` cycles or fewer never reach `scl_filt`.
- R6: `sample_stb` is a single-cycle pulse in the first cycle of each high count, and it is only asserted while `scl_filt` is 1.
- R7: Exactly one `update_stb` pulse occurs per low phase, in low cycle `tx_hold` (counted from 0 at the first cycle with `scl_oe` = 1). If `tx_hold` is not below the low length, the pulse occurs in the last low cycle.
- R8: With `run` = 0 in idle, nothing changes. `run` is sampled when the high count ends; if it is 0, the block returns to idle with `scl_oe` = 0 and `busy` = 0.
- R9: The selected counts are taken at the start of each phase, so a change of `speed_sel` or of a count register takes effect from the next phase on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Generate SCL periods while high |
| speed_sel | input | 2 | Speed mode: 0 standard, 1 fast, 2 high speed, 3 as standard |
| std_hi | input | 16 | Standard-mode high count |
| std_lo | input | 16 | Standard-mode low count |
| fast_hi | input | 16 | Fast-mode high count |
| fast_lo | input | 16 | Fast-mode low count |
| hs_hi | input | 16 | High-speed-mode high count |
| hs_lo | input | 16 | High-speed-mode low count |
| spike_len | input | 8 | Longest ignored glitch, in cycles |
| fall_cyc | input | 8 | SCL fall-edge compensation, in cycles |
| rise_cyc | input | 8 | SCL rise-edge compensation, in cycles |
| tx_hold | input | 16 | SDA update delay after SCL is pulled low, in cycles |
| scl_in | input | 1 | Sampled SCL line |
| scl_oe | output | 1 | Open-drain pull-down enable for SCL |
| scl_filt | output | 1 | Synchronised and spike-filtered SCL |
| sample_stb | output | 1 | One-cycle SDA sample strobe |
| update_stb | output | 1 | One-cycle SDA update strobe |
| busy | output | 1 | Generator is not idle |

## Verification
A wrong phase state or count shows up as an early or late edge of `scl_oe`. The reference model sees it in the same cycle, at the latest one full period after the fault. A corrupted spike-filter counter shows up within `spike_len`+3 cycles as a `scl_filt` that differs from the model, or as a missing or extra `sample_stb`. A broken hold counter moves or duplicates `update_stb` inside the same low phase. The bench stretches the rising edge and injects glitches that are just short enough to be ignored, so that faults in the filter and in the wait for a high line cannot hide.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    localparam int CNT_W    = 16;
    localparam int SPK_W    = 8;
    localparam int EDGE_W   = 8;
    localparam int HOLD_W   = 16;
    localparam int TOT_W    = CNT_W + 2;
    localparam int HI_FIXED = 7;
    localparam int LO_FIXED = 1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_RISE = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        SPD_STD  = 2'd0,
        SPD_FAST = 2'd1,
        SPD_HS   = 2'd2,
        SPD_RSVD = 2'd3
    } speed_e;

    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } cnt_pair_t;

    function automatic cnt_pair_t pick_pair(input logic [1:0] sel,
                                            input cnt_pair_t s,
                                            input cnt_pair_t f,
                                            input cnt_pair_t h);
        case (speed_e'(sel))
            SPD_FAST: return f;
            SPD_HS:   return h;
            default:  return s;
        endcase
    endfunction

    function automatic logic [TOT_W-1:0] high_total(input logic [CNT_W-1:0]  hi,
                                                    input logic [SPK_W-1:0]  spk,
                                                    input logic [EDGE_W-1:0] fall);
        return TOT_W'(hi) + TOT_W'(spk) + TOT_W'(HI_FIXED) + TOT_W'(fall);
    endfunction

    function automatic logic [TOT_W-1:0] low_total(input logic [CNT_W-1:0]  lo,
                                                   input logic [EDGE_W-1:0] rise);
        return TOT_W'(lo) + TOT_W'(LO_FIXED) + TOT_W'(rise);
    endfunction

endpackage

// File: rtl/scl_glitch_filter.sv
module scl_glitch_filter
    import scl_timing_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_in,
    input  logic [SPK_W-1:0] spike_len,
    output logic             filt_out
);

    logic             sync_q;
    logic             filt_q;
    logic [SPK_W-1:0] run_cnt;

    generate
        if (SYNC_STAGES > 1) begin : g_multi
            logic [SYNC_STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[SYNC_STAGES-2:0], raw_in};
            end
            assign sync_q = chain[SYNC_STAGES-1];
        end else begin : g_single
            logic one;
            always_ff @(posedge clk) begin
                if (rst) one <= 1'b1;
                else     one <= raw_in;
            end
            assign sync_q = one;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q  <= 1'b1;
            run_cnt <= '0;
        end else if (sync_q != filt_q) begin
            if (run_cnt == spike_len) begin
                filt_q  <= sync_q;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + SPK_W'(1);
            end
        end else begin
            run_cnt <= '0;
        end
    end

    assign filt_out = filt_q;

    AST_FILT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (sync_q == filt_q) |=> $stable(filt_q)); // R5

    AST_FILT_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        (sync_q != filt_q && run_cnt != spike_len) |=> $stable(filt_q)); // R5

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer
    import scl_timing_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             scl_filt,
    input  logic [TOT_W-1:0] hi_total,
    input  logic [TOT_W-1:0] lo_total,
    output logic             low_load,
    output logic             low_last,
    output logic             scl_oe,
    output logic             sample_stb,
    output logic             busy
);

    phase_e           ph;
    logic [TOT_W-1:0] cnt;
    logic             cnt_zero;

    assign cnt_zero = (cnt == '0);

    always_comb begin
        low_load = run && ((ph == PH_IDLE) || (ph == PH_HIGH && cnt_zero));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (low_load) begin
                        ph  <= PH_LOW;
                        cnt <= lo_total - TOT_W'(1);
                    end
                end
                PH_LOW: begin
                    if (cnt_zero) ph <= PH_RISE;
                    else          cnt <= cnt - TOT_W'(1);
                end
                PH_RISE: begin
                    if (scl_filt) begin
                        ph  <= PH_HIGH;
                        cnt <= hi_total - TOT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (cnt_zero) begin
                        if (low_load) begin
                            ph  <= PH_LOW;
                            cnt <= lo_total - TOT_W'(1);
                        end else begin
                            ph <= PH_IDLE;
                        end
                    end else begin
                        cnt <= cnt - TOT_W'(1);
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign scl_oe     = (ph == PH_LOW);
    assign low_last   = (ph == PH_LOW) && cnt_zero;
    assign sample_stb = (ph == PH_RISE) && scl_filt;
    assign busy       = (ph != PH_IDLE);

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_IDLE && !run) |=> (ph == PH_IDLE)); // R8

    AST_RISE_WAITS: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_RISE && !scl_filt) |=> (ph == PH_RISE && !scl_oe)); // R4

    AST_LOW_ENDS_RELEASED: assert property (@(posedge clk) disable iff (rst)
        low_last |=> !scl_oe); // R3

endmodule

// File: rtl/sda_hold_timer.sv
module sda_hold_timer
    import scl_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              in_low,
    input  logic              low_last,
    input  logic [HOLD_W-1:0] hold_cyc,
    output logic              update_stb
);

    logic              armed;
    logic [HOLD_W-1:0] left;
    logic              fire;

    assign fire       = in_low && armed && ((left == '0) || low_last);
    assign update_stb = fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            left  <= '0;
        end else if (load) begin
            armed <= 1'b1;
            left  <= hold_cyc;
        end else if (in_low && armed) begin
            if (fire) armed <= 1'b0;
            else      left  <= left - HOLD_W'(1);
        end
    end

    AST_HOLD_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(in_low) |-> !armed); // R7

    AST_HOLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        update_stb |=> !update_stb); // R7

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [1:0]        speed_sel,
    input  logic [CNT_W-1:0]  std_hi,
    input  logic [CNT_W-1:0]  std_lo,
    input  logic [CNT_W-1:0]  fast_hi,
    input  logic [CNT_W-1:0]  fast_lo,
    input  logic [CNT_W-1:0]  hs_hi,
    input  logic [CNT_W-1:0]  hs_lo,
    input  logic [SPK_W-1:0]  spike_len,
    input  logic [EDGE_W-1:0] fall_cyc,
    input  logic [EDGE_W-1:0] rise_cyc,
    input  logic [HOLD_W-1:0] tx_hold,
    input  logic              scl_in,
    output logic              scl_oe,
    output logic              scl_filt,
    output logic              sample_stb,
    output logic              update_stb,
    output logic              busy
);

    cnt_pair_t        sel_pair;
    logic [TOT_W-1:0] hi_total;
    logic [TOT_W-1:0] lo_total;
    logic             low_load;
    logic             low_last;

    always_comb begin
        sel_pair = pick_pair(speed_sel,
                             '{hi: std_hi,  lo: std_lo},
                             '{hi: fast_hi, lo: fast_lo},
                             '{hi: hs_hi,   lo: hs_lo});
        hi_total = high_total(sel_pair.hi, spike_len, fall_cyc);
        lo_total = low_total(sel_pair.lo, rise_cyc);
    end

    scl_glitch_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
        .clk       (clk),
        .rst       (rst),
        .raw_in    (scl_in),
        .spike_len (spike_len),
        .filt_out  (scl_filt)
    );

    scl_phase_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .scl_filt   (scl_filt),
        .hi_total   (hi_total),
        .lo_total   (lo_total),
        .low_load   (low_load),
        .low_last   (low_last),
        .scl_oe     (scl_oe),
        .sample_stb (sample_stb),
        .busy       (busy)
    );

    sda_hold_timer u_hold (
        .clk        (clk),
        .rst        (rst),
        .load       (low_load),
        .in_low     (scl_oe),
        .low_last   (low_last),
        .hold_cyc   (tx_hold),
        .update_stb (update_stb)
    );

    AST_SAMPLE_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> scl_filt); // R6

    AST_UPDATE_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        update_stb |-> scl_oe); // R7

    AST_SAMPLE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb); // R6

    AST_RELEASED_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !scl_oe); // R8

endmodule

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;
    import scl_timing_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic [1:0] speed_sel = 2'd0;
    logic [CNT_W-1:0] std_hi = 16'd2, std_lo = 16'd3;
    logic [CNT_W-1:0] fast_hi = 16'd1, fast_lo = 16'd2;
    logic [CNT_W-1:0] hs_hi = 16'd0, hs_lo = 16'd1;
    logic [SPK_W-1:0] spike_len = 8'd1;
    logic [EDGE_W-1:0] fall_cyc = 8'd1, rise_cyc = 8'd2;
    logic [HOLD_W-1:0] tx_hold = 16'd1;
    logic scl_in = 1'b1;
    logic scl_oe, scl_filt, sample_stb, update_stb, busy;

    always #5 clk = ~clk;

    scl_timing_gen dut (
        .clk(clk), .rst(rst), .run(run), .speed_sel(speed_sel),
        .std_hi(std_hi), .std_lo(std_lo), .fast_hi(fast_hi), .fast_lo(fast_lo),
        .hs_hi(hs_hi), .hs_lo(hs_lo), .spike_len(spike_len),
        .fall_cyc(fall_cyc), .rise_cyc(rise_cyc), .tx_hold(tx_hold),
        .scl_in(scl_in), .scl_oe(scl_oe), .scl_filt(scl_filt),
        .sample_stb(sample_stb), .update_stb(update_stb), .busy(busy)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Behavioural reference model
    int q[$] = '{1, 1};
    int m_f = 1, m_fc = 0, m_st = 0, m_cnt = 0, m_hact = 0, m_hcnt = 0;

    function automatic int sel_lo();
        case (speed_sel)
            2'd1: return int'(fast_lo);
            2'd2: return int'(hs_lo);
            default: return int'(std_lo);
        endcase
    endfunction
    function automatic int sel_hi();
        case (speed_sel)
            2'd1: return int'(fast_hi);
            2'd2: return int'(hs_hi);
            default: return int'(std_hi);
        endcase
    endfunction

    task automatic model_step();
        int lo_t, hi_t, old_s2;
        if (rst) begin
            q = '{1, 1}; m_f = 1; m_fc = 0; m_st = 0; m_cnt = 0; m_hact = 0; m_hcnt = 0;
            return;
        end
        lo_t = sel_lo() + 1 + int'(rise_cyc);
        hi_t = sel_hi() + int'(spike_len) + 7 + int'(fall_cyc);
        case (m_st)
            0: if (run) begin m_st = 1; m_cnt = lo_t - 1; m_hact = 1; m_hcnt = int'(tx_hold); end
            1: begin
                if (m_hact != 0) begin
                    if (m_hcnt == 0 || m_cnt == 0) m_hact = 0; else m_hcnt--;
                end
                if (m_cnt == 0) m_st = 2; else m_cnt--;
            end
            2: if (m_f != 0) begin m_st = 3; m_cnt = hi_t - 1; end
            default: begin
                if (m_cnt == 0) begin
                    if (run) begin m_st = 1; m_cnt = lo_t - 1; m_hact = 1; m_hcnt = int'(tx_hold); end
                    else m_st = 0;
                end else m_cnt--;
            end
        endcase
        old_s2 = q[1];
        if (old_s2 != m_f) begin
            if (m_fc == int'(spike_len)) begin m_f = old_s2; m_fc = 0; end
            else m_fc++;
        end else m_fc = 0;
        q.push_front(int'(scl_in));
        void'(q.pop_back());
    endtask

    // Bus environment and direct measurements
    int rise_dly = 1;
    int rel = 1000;
    int glitch_req = 0, glitch_left = 0;
    string tag_oe = "R3";
    string tag_len = "R3";
    bit len_en = 1;
    int lowlen = 0;
    bit prev_oe = 0;
    int oe_rises = 0;

    task automatic tick();
        int exp_low;
        bit v;
        @(posedge clk);
        model_step();
        @(negedge clk);
        if (!rst) begin
            chk(scl_oe == (m_st == 1), tag_oe, int'(scl_oe), int'(m_st == 1));
            chk(scl_filt == (m_f != 0), "R5", int'(scl_filt), m_f);
            chk(sample_stb == (m_st == 2 && m_f != 0), "R6", int'(sample_stb), int'(m_st == 2 && m_f != 0));
            chk(update_stb == (m_st == 1 && m_hact != 0 && (m_hcnt == 0 || m_cnt == 0)), "R7",
                int'(update_stb), int'(m_st == 1 && m_hact != 0 && (m_hcnt == 0 || m_cnt == 0)));
            chk(busy == (m_st != 0), "R8", int'(busy), int'(m_st != 0));
            exp_low = sel_lo() + 1 + int'(rise_cyc);
            if (scl_oe) lowlen++;
            else if (prev_oe) begin
                if (len_en) chk(lowlen == exp_low, tag_len, lowlen, exp_low);
                lowlen = 0;
            end
            if (scl_oe && !prev_oe) oe_rises++;
            prev_oe = scl_oe;
        end
        if (sample_stb && glitch_req > 0) begin glitch_left = glitch_req; glitch_req = 0; end
        if (scl_oe) rel = 0; else rel++;
        v = !scl_oe && (rel > rise_dly);
        if (glitch_left > 0) begin v = 1'b0; glitch_left--; end
        scl_in = v;
    endtask

    task automatic periods(input int n);
        int start;
        start = oe_rises;
        run = 1'b1;
        for (int i = 0; i < 5000 && (oe_rises - start) < n; i++) tick();
        run = 1'b0;
        for (int i = 0; i < 5000 && busy; i++) tick();
        chk(!busy && !scl_oe, "R8", int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) tick();
        rst = 1'b0;
        tick();
        // R1: reset state
        chk(!scl_oe && !sample_stb && !update_stb && !busy, "R1", int'(scl_oe | busy), 0);
        chk(scl_filt == 1'b1, "R1", int'(scl_filt), 1);
        // R8: idle with run low stays quiet
        repeat (10) tick();
        chk(!busy && !scl_oe, "R8", int'(busy), 0);

        // standard mode, short hold
        periods(3);

        // fast mode, hold beyond low phase: clamps to last low cycle (R7)
        speed_sel = 2'd1; tx_hold = 16'd40;
        periods(3);

        // high speed, no spike filter, slow rise (R4)
        speed_sel = 2'd2; spike_len = 8'd0; tx_hold = 16'd0; rise_dly = 6; tag_oe = "R4";
        periods(3);

        // reserved select uses standard pair (R2)
        speed_sel = 2'd3; spike_len = 8'd2; rise_dly = 1; tag_oe = "R3"; tag_len = "R2";
        std_lo = 16'd7; std_hi = 16'd5; tx_hold = 16'd3;
        periods(2);
        tag_len = "R3";

        // glitches of spike_len cycles during high are ignored (R5)
        spike_len = 8'd3; std_hi = 16'd8; speed_sel = 2'd0;
        run = 1'b1;
        for (int k = 0; k < 4; k++) begin
            glitch_req = 3;
            for (int i = 0; i < 200 && glitch_req != 0; i++) tick();
            for (int i = 0; i < 6; i++) begin
                tick();
                chk(scl_filt == 1'b1 || scl_oe, "R5", int'(scl_filt), 1);
            end
        end
        periods(1);

        // longer glitch is adopted and seen by the model (R5)
        spike_len = 8'd1; glitch_req = 4;
        periods(3);

        // speed change mid-period takes effect from next phase (R9)
        tag_oe = "R9"; len_en = 0;
        run = 1'b1; speed_sel = 2'd0;
        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 7; i++) tick();
            speed_sel = (speed_sel == 2'd0) ? 2'd1 : 2'd0;
            fast_lo = fast_lo + 16'd1;
        end
        periods(1);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule